// File: doc/BRIEF.md
# Paged Capture Ring with Completion-Locked Readout

This block holds a run of narrow samples in a circular store and hands them out in fixed-size pages over a slow readout path. The capture side is armed with a target sample count. It then accepts one sample per cycle whenever its valid input is high, wrapping around the ring, and raises a completion flag once the target count has been stored. From that point the ring is frozen: later writes are dropped and the write pointer no longer moves. Successive pages therefore line up with no samples missing between them.

A page is two 32-sample blocks, 64 samples in all. A request names a page index. The block answers with the 64 samples in ascending logical order, one per cycle, and marks the final one. When the capture wrapped, logical sample 0 is the oldest sample still held. Requests that arrive before completion, or that name a page beyond the captured data, are refused with a status code and return no samples. Re-arming clears the completion flag at once and cuts off any readout in progress, so a stale completion is never seen.

Top module: `cap_page_buf`

## Requirements
- R1: After reset, `done_o`, `rsp_valid_o`, `rsp_last_o` and `rsp_err_o` are all low.
- R2: A cycle with `arm_i` high clears `done_o` by the next cycle and restarts storage at ring position 0; a write in that same cycle is dropped.
- R3: The target count is `cap_len_i` latched at arm, with 0 treated as 1. `done_o` goes high in the cycle after the write that brings the stored count to the target, and not before.
- R4: Only cycles with `wr_valid_i` high while capturing store a sample. Writes once `done_o` is high, and cycles with `wr_valid_i` low, leave the stored data unchanged.
- R5: A request while `done_o` is low produces a one-cycle `rsp_err_o` pulse with `rsp_code_o` = 1 (not ready) and no `rsp_valid_o`.
- R6: An accepted request for page p returns logical samples 64p to 64p+63 in ascending order on 64 consecutive `rsp_valid_o` cycles, with `rsp_last_o` high only on the 64th.
- R7: If more than DEPTH samples were stored, logical sample 0 is the oldest sample still held. Otherwise it is the first sample stored after arm.
- R8: A request for a page whose first logical sample is at or beyond the number of samples held (the stored count capped at DEPTH) produces `rsp_err_o` with `rsp_code_o` = 2 (bad page) and no data.
- R9: While `done_o` stays high, back-to-back and repeated page reads return data consistent with one frozen ring, with no samples skipped between pages.
- R10: A request arriving while a page is streaming is ignored. An arm during streaming stops the stream within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Start a new capture |
| cap_len_i | input | CNT_W (10) | Target sample count, latched at arm |
| wr_valid_i | input | 1 | Sample present on `wr_data_i` |
| wr_data_i | input | SW (8) | Capture sample |
| done_o | output | 1 | Capture complete, readout allowed |
| rd_req_i | input | 1 | Page read request, one-cycle pulse |
| rd_page_i | input | PAGE_W (3) | Requested page index |
| rsp_valid_o | output | 1 | Readout sample valid |
| rsp_data_o | output | SW (8) | Readout sample |
| rsp_last_o | output | 1 | Final sample of the page |
| rsp_err_o | output | 1 | Request refused |
| rsp_code_o | output | 2 | Refusal reason: 1 not ready, 2 bad page |

## Verification
The bench targets the cases where a readout path can leak stale or shifted data. One is a request before completion, which a design that left the flag set would answer with old samples. Another is a capture longer than the ring: a design that kept logical zero at position 0 would return the newest samples ahead of the oldest. Writes pushed after completion and a second request fired mid-stream check the frozen ring; a design that let either through would corrupt or restart the page. A zero-length target and an arm during streaming cover the edges of the completion flag itself.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

   typedef enum logic [1:0] {
      RSP_OK        = 2'd0,
      RSP_NOT_READY = 2'd1,
      RSP_BAD_PAGE  = 2'd2
   } rsp_code_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cpb_ring_mem.sv
module cpb_ring_mem #(
   parameter int unsigned SW    = 8,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [SW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [SW-1:0] rd_data
);

   logic [SW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= store[rd_addr];
   end

endmodule

// File: rtl/cpb_capture_ctrl.sv
module cpb_capture_ctrl #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned CNT_W = 10,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic [CNT_W-1:0] cap_len,
   input  logic             wr_valid,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_addr,
   output logic             done,
   output logic [PTR_W-1:0] start_ptr,
   output logic [PTR_W:0]   filled
);

   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] ptr_nxt;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] count_nxt;
   logic [CNT_W-1:0] target;
   logic             capturing;
   logic             wrapped;
   logic             at_top;

   assign at_top = (wr_ptr == PTR_W'(DEPTH - 1));

   generate
      if (cpb_pkg::is_pow2(DEPTH)) begin : g_ptr_p2
         assign ptr_nxt = wr_ptr + 1'b1;
      end else begin : g_ptr_np2
         assign ptr_nxt = at_top ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   assign count_nxt = count + 1'b1;
   assign wr_en     = capturing && wr_valid && !arm;
   assign wr_addr   = wr_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         count     <= '0;
         target    <= '0;
         capturing <= 1'b0;
         wrapped   <= 1'b0;
         done      <= 1'b0;
      end else if (arm) begin
         wr_ptr    <= '0;
         count     <= '0;
         target    <= (cap_len == '0) ? CNT_W'(1) : cap_len;
         capturing <= 1'b1;
         wrapped   <= 1'b0;
         done      <= 1'b0;
      end else if (wr_en) begin
         wr_ptr <= ptr_nxt;
         count  <= count_nxt;
         if (at_top) wrapped <= 1'b1;
         if (count_nxt == target) begin
            done      <= 1'b1;
            capturing <= 1'b0;
         end
      end
   end

   assign start_ptr = wrapped ? wr_ptr : '0;
   assign filled    = wrapped ? (PTR_W + 1)'(DEPTH) : {1'b0, wr_ptr};

endmodule

// File: rtl/cpb_page_reader.sv
module cpb_page_reader #(
   parameter int unsigned DEPTH    = 256,
   parameter int unsigned PAGE_LEN = 64,
   parameter int unsigned PAGE_W   = 3,
   localparam int unsigned PTR_W   = $clog2(DEPTH),
   localparam int unsigned IDX_W   = $clog2(PAGE_LEN),
   localparam int unsigned CMP_W   = PAGE_W + IDX_W + PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              done,
   input  logic              rd_req,
   input  logic [PAGE_W-1:0] rd_page,
   input  logic [PTR_W-1:0]  start_ptr,
   input  logic [PTR_W:0]    filled,
   output logic              mem_rd_en,
   output logic [PTR_W-1:0]  mem_rd_addr,
   output logic              rsp_valid,
   output logic              rsp_last,
   output logic              rsp_err,
   output logic [1:0]        rsp_code
);

   import cpb_pkg::*;

   logic             busy;
   logic [IDX_W-1:0] idx;
   logic [PTR_W-1:0] page_base;
   logic [CMP_W-1:0] page_ofs;
   logic [CMP_W-1:0] filled_ext;
   logic             idx_end;
   rsp_code_e        code_q;

   assign page_ofs   = CMP_W'(rd_page) << IDX_W;
   assign filled_ext = CMP_W'(filled);
   assign idx_end    = (idx == IDX_W'(PAGE_LEN - 1));
   assign mem_rd_en  = busy && !arm;

   generate
      if (cpb_pkg::is_pow2(DEPTH)) begin : g_addr_p2
         assign mem_rd_addr = start_ptr + page_base + PTR_W'(idx);
      end else begin : g_addr_np2
         logic [PTR_W:0] sum;
         assign sum = {1'b0, start_ptr} + {1'b0, page_base} + (PTR_W + 1)'(idx);
         assign mem_rd_addr = (sum >= (PTR_W + 1)'(DEPTH))
                              ? PTR_W'(sum - (PTR_W + 1)'(DEPTH))
                              : sum[PTR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         idx       <= '0;
         page_base <= '0;
         rsp_valid <= 1'b0;
         rsp_last  <= 1'b0;
         rsp_err   <= 1'b0;
         code_q    <= RSP_OK;
      end else begin
         rsp_err   <= 1'b0;
         code_q    <= RSP_OK;
         rsp_valid <= busy && !arm;
         rsp_last  <= busy && !arm && idx_end;
         if (arm) begin
            busy <= 1'b0;
         end else if (busy) begin
            idx <= idx + 1'b1;
            if (idx_end) busy <= 1'b0;
         end else if (rd_req) begin
            if (!done) begin
               rsp_err <= 1'b1;
               code_q  <= RSP_NOT_READY;
            end else if (page_ofs >= filled_ext) begin
               rsp_err <= 1'b1;
               code_q  <= RSP_BAD_PAGE;
            end else begin
               busy      <= 1'b1;
               idx       <= '0;
               page_base <= page_ofs[PTR_W-1:0];
            end
         end
      end
   end

   assign rsp_code = code_q;

endmodule

// File: rtl/cap_page_buf.sv
module cap_page_buf #(
   parameter int unsigned SW              = 8,
   parameter int unsigned BLOCK_LEN       = 32,
   parameter int unsigned BLOCKS_PER_PAGE = 2,
   parameter int unsigned DEPTH           = 256,
   parameter int unsigned MAX_LEN         = 1023,
   localparam int unsigned PAGE_LEN  = BLOCK_LEN * BLOCKS_PER_PAGE,
   localparam int unsigned NUM_PAGES = DEPTH / PAGE_LEN,
   localparam int unsigned PTR_W     = $clog2(DEPTH),
   localparam int unsigned PAGE_W    = $clog2(NUM_PAGES) + 1,
   localparam int unsigned CNT_W     = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic [CNT_W-1:0]  cap_len_i,
   input  logic              wr_valid_i,
   input  logic [SW-1:0]     wr_data_i,
   output logic              done_o,
   input  logic              rd_req_i,
   input  logic [PAGE_W-1:0] rd_page_i,
   output logic              rsp_valid_o,
   output logic [SW-1:0]     rsp_data_o,
   output logic              rsp_last_o,
   output logic              rsp_err_o,
   output logic [1:0]        rsp_code_o
);

   generate
      if (!cpb_pkg::is_pow2(PAGE_LEN)) begin : g_bad_page_len
         $error("cap_page_buf: page length must be a power of two");
      end
      if ((DEPTH % PAGE_LEN) != 0 || DEPTH < PAGE_LEN) begin : g_bad_depth
         $error("cap_page_buf: depth must be a whole number of pages");
      end
      if (SW == 0) begin : g_bad_sw
         $error("cap_page_buf: sample width must be nonzero");
      end
   endgenerate

   logic             wr_en;
   logic [PTR_W-1:0] wr_addr;
   logic [PTR_W-1:0] start_ptr;
   logic [PTR_W:0]   filled;
   logic             mem_rd_en;
   logic [PTR_W-1:0] mem_rd_addr;

   cpb_capture_ctrl #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm       (arm_i),
      .cap_len   (cap_len_i),
      .wr_valid  (wr_valid_i),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .done      (done_o),
      .start_ptr (start_ptr),
      .filled    (filled)
   );

   cpb_ring_mem #(
      .SW    (SW),
      .DEPTH (DEPTH)
   ) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data_i),
      .rd_en   (mem_rd_en),
      .rd_addr (mem_rd_addr),
      .rd_data (rsp_data_o)
   );

   cpb_page_reader #(
      .DEPTH    (DEPTH),
      .PAGE_LEN (PAGE_LEN),
      .PAGE_W   (PAGE_W)
   ) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .arm         (arm_i),
      .done        (done_o),
      .rd_req      (rd_req_i),
      .rd_page     (rd_page_i),
      .start_ptr   (start_ptr),
      .filled      (filled),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_addr (mem_rd_addr),
      .rsp_valid   (rsp_valid_o),
      .rsp_last    (rsp_last_o),
      .rsp_err     (rsp_err_o),
      .rsp_code    (rsp_code_o)
   );

endmodule

// File: rtl/cap_page_buf_chk.sv
module cap_page_buf_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       arm_i,
   input logic       wr_valid_i,
   input logic       rd_req_i,
   input logic       done_o,
   input logic       rsp_valid_o,
   input logic       rsp_last_o,
   input logic       rsp_err_o,
   input logic [1:0] rsp_code_o
);

   // R2: arming always clears completion on the next cycle
   a_r2_arm_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> !done_o);

   // R3: completion only follows a write cycle
   a_r3_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(wr_valid_i));

   // R3: completion holds until the next arm
   a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !arm_i) |=> done_o);

   // R5: no sample leaves while capture is incomplete
   a_r5_no_data_before_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> done_o);

   // R5: refusal carries a non-OK code and never data
   a_r5_err_code: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err_o |-> (rsp_code_o != 2'd0 && !rsp_valid_o));

   // R6: the last marker only rides on a valid sample
   a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last_o |-> rsp_valid_o);

   // R10: an arm stops any stream by the next cycle
   a_r10_arm_stops_stream: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i |=> !rsp_valid_o);

   // R10: a request during streaming is not refused
   a_r10_busy_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && !rsp_last_o && rd_req_i && !arm_i) |=> !rsp_err_o);

endmodule

bind cap_page_buf cap_page_buf_chk u_chk (.*);

// File: tb/cap_page_buf_test.sv
module cap_page_buf_test;

   localparam int DEPTH = 256;
   localparam int PLEN  = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arm_i = 1'b0;
   logic [9:0] cap_len_i = '0;
   logic       wr_valid_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic       done_o;
   logic       rd_req_i = 1'b0;
   logic [2:0] rd_page_i = '0;
   logic       rsp_valid_o;
   logic [7:0] rsp_data_o;
   logic       rsp_last_o;
   logic       rsp_err_o;
   logic [1:0] rsp_code_o;

   cap_page_buf uut (.*);

   always #10 clk = ~clk;

   int n_run = 0;
   int n_fail = 0;

   // bench model
   logic [7:0] hist [2048];
   int n_acc = 0;
   int target = 1;
   bit cap_on = 0;

   // read results
   logic [7:0] rbuf [128];
   int  r_got;
   int  r_last_at;
   int  r_first_i;
   int  r_end_i;
   bit  r_err;
   logic [1:0] r_code;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_at(input int l);
      if (n_acc > DEPTH) return hist[n_acc - DEPTH + l];
      return hist[l];
   endfunction

   task automatic model_arm(input int len);
      n_acc  = 0;
      target = (len == 0) ? 1 : len;
      cap_on = 1;
   endtask

   task automatic do_arm(input int len);
      arm_i = 1'b1;
      cap_len_i = 10'(len);
      model_arm(len);
      @(negedge clk);
      arm_i = 1'b0;
   endtask

   task automatic push(input logic [7:0] d, input int gap);
      wr_valid_i = 1'b1;
      wr_data_i  = d;
      if (cap_on) begin
         hist[n_acc] = d;
         n_acc++;
         if (n_acc == target) cap_on = 0;
      end
      @(negedge clk);
      wr_valid_i = 1'b0;
      wr_data_i  = ~d;
      repeat (gap) @(negedge clk);
   endtask

   // poke: iteration at which a second request is fired; arm_at: iteration of an arm
   task automatic read_page(input int page, input int poke, input int arm_at);
      r_got = 0; r_last_at = -1; r_first_i = -1; r_end_i = -1;
      r_err = 0; r_code = 2'd0;
      rd_req_i = 1'b1;
      rd_page_i = 3'(page);
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         rd_req_i = 1'b0;
         arm_i = 1'b0;
         if (rsp_valid_o) begin
            if (r_first_i < 0) r_first_i = i;
            r_end_i = i;
            rbuf[r_got] = rsp_data_o;
            if (rsp_last_o) r_last_at = r_got;
            r_got++;
         end
         if (rsp_err_o) begin
            r_err = 1;
            r_code = rsp_code_o;
         end
         if (i == poke) begin
            rd_req_i = 1'b1;
            rd_page_i = 3'(page + 1);
         end
         if (i == arm_at) begin
            arm_i = 1'b1;
            cap_len_i = 10'd64;
            model_arm(64);
         end
      end
   endtask

   task automatic check_page(input int page, input string req);
      int bad = 0;
      int first_bad = -1;
      check(r_got == PLEN, req, "sample count", r_got, PLEN);
      check(r_last_at == PLEN - 1, req, "last position", r_last_at, PLEN - 1);
      check(r_end_i - r_first_i + 1 == r_got, req, "consecutive cycles",
            r_end_i - r_first_i + 1, r_got);
      for (int k = 0; k < PLEN; k++) begin
         if (rbuf[k] !== exp_at(page * PLEN + k)) begin
            bad++;
            if (first_bad < 0) first_bad = k;
         end
      end
      if (first_bad < 0) check(1, req, "page data", 0, 0);
      else check(0, req, "page data",
                 int'(rbuf[first_bad]), int'(exp_at(page * PLEN + first_bad)));
   endtask

   task automatic t_reset;
      check(done_o == 1'b0, "R1", "done after reset", done_o, 0);
      check(rsp_valid_o == 1'b0 && rsp_last_o == 1'b0, "R1", "valid/last after reset",
            rsp_valid_o, 0);
      check(rsp_err_o == 1'b0, "R1", "err after reset", rsp_err_o, 0);
   endtask

   task automatic t_not_ready;
      read_page(0, -1, -1);
      check(r_err && r_code == 2'd1, "R5", "not-ready code", r_code, 1);
      check(r_got == 0, "R5", "no data before done", r_got, 0);
   endtask

   task automatic t_short_capture;
      do_arm(128);
      check(done_o == 1'b0, "R2", "done after arm", done_o, 0);
      for (int k = 0; k < 127; k++) push(8'(k * 37 + 5), k % 3);
      check(done_o == 1'b0, "R3", "done one short of target", done_o, 0);
      push(8'hA5, 0);
      check(done_o == 1'b1, "R3", "done at target", done_o, 1);
      read_page(0, -1, -1);
      check_page(0, "R6");
      read_page(1, -1, -1);
      check_page(1, "R6");
      read_page(2, -1, -1);
      check(r_err && r_code == 2'd2, "R8", "bad-page code", r_code, 2);
      check(r_got == 0, "R8", "no data on bad page", r_got, 0);
      for (int k = 0; k < 5; k++) push(8'hEE, 0);
      read_page(1, -1, -1);
      check_page(1, "R4");
      read_page(0, -1, -1);
      check_page(0, "R9");
   endtask

   task automatic t_wrap_capture;
      do_arm(300);
      for (int k = 0; k < 300; k++) push(8'(k * 53 + 11), 0);
      check(done_o == 1'b1, "R3", "done after 300", done_o, 1);
      for (int p = 0; p < 4; p++) begin
         read_page(p, -1, -1);
         check_page(p, "R7");
      end
      read_page(4, -1, -1);
      check(r_err && r_code == 2'd2, "R8", "page past ring", r_code, 2);
      read_page(2, -1, -1);
      check_page(2, "R9");
   endtask

   task automatic t_busy_ignore;
      read_page(1, 20, -1);
      check_page(1, "R10");
      check(r_err == 0, "R10", "no refusal mid-stream", r_err, 0);
   endtask

   task automatic t_abort;
      read_page(0, -1, 10);
      check(r_got > 0 && r_got < PLEN, "R10", "stream cut by arm", r_got, 10);
      check(r_last_at < 0, "R10", "no last after abort", r_last_at, -1);
      check(done_o == 1'b0, "R2", "done cleared by arm", done_o, 0);
      read_page(0, -1, -1);
      check(r_err && r_code == 2'd1, "R5", "stale done not reported", r_code, 1);
   endtask

   task automatic t_zero_len;
      do_arm(0);
      push(8'h3C, 0);
      check(done_o == 1'b1, "R3", "zero target acts as one", done_o, 1);
      push(8'hC3, 0);
      read_page(0, -1, -1);
      check(r_got == PLEN && rbuf[0] == 8'h3C, "R2", "sample at position 0",
            int'(rbuf[0]), 8'h3C);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_not_ready();
      t_short_capture();
      t_wrap_capture();
      t_busy_ignore();
      t_abort();
      t_zero_len();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule